// File: doc/BRIEF.md
# Rotated Immediate Constant Encoder

The block decides whether a 32-bit constant can be carried in the 12-bit immediate field of a 32-bit instruction word. That field does not hold a signed literal. It holds an 8-bit byte and a 4-bit rotate count, and its value is the byte rotated right inside a 32-bit word by twice the count. Because the value is not a plain range, the block has to search for a rotation. It tries rotate counts in increasing order, one group of probes per clock. For each count it rotates the candidate left by twice the count and tests whether bits 31:8 of the result are all clear. The first count that passes gives the field, so the block always returns the smallest rotate count that works.

A request is taken over a valid/ready handshake. The result is an encodable flag plus the 12-bit field, and it is held until the consumer accepts it. The block takes no new request while a search is running or while a result is waiting. A separate combinational decoder expands any 12-bit field back into 32 bits, so a tool flow or a bench can confirm an encoding. In the default configuration one rotate count is probed per cycle. A parameter can widen the search to several counts per cycle.

Top module: `imm_rot_encoder`

## Requirements
- R1: After a synchronous active-high reset, and in every cycle after that until a request is accepted, in_ready is 1 and out_valid is 0.
- R2: For an encodable constant the result has out_hit = 1. out_field holds the rotate count in bits 11:8 and the byte in bits 7:0, and the byte rotated right by twice the count equals the constant.
- R3: When several rotate counts fit, the reported field uses the smallest one. For example, 0x00000010 gives 0x010, not 0xE01.
- R4: A constant that fits no rotation gives out_hit = 0 and out_field = 0x000. Small values such as 0x3FF and 0x101 are misses, because signed-range encoding is not offered.
- R5: With the default of one probe per cycle, out_valid rises c+1 clock edges after the accepting edge when the smallest fitting count is c. On a miss it rises 16 edges after the accepting edge.
- R6: in_ready is 0 from the edge that accepts a request until the edge that retires its result. Requests presented during that time are ignored.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_hit and out_field hold their values. The edge with out_ready = 1 retires the result and returns the block to idle.
- R8: dec_value equals dec_field[7:0] rotated right by 2*dec_field[11:8], combinationally. Field 0xFFF decodes to 0x000003FC.
- R9: The constant 0x23 encodes as 0x023, 0x23000000 encodes as 0x423, and 0x00000000 encodes as 0x000 with out_hit = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A constant is offered |
| in_ready | output | 1 | The block is idle and accepts a constant |
| in_value | input | 32 | Constant to encode |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result |
| out_hit | output | 1 | 1 when the constant is encodable |
| out_field | output | 12 | Rotate count (11:8) and byte (7:0), zero on a miss |
| dec_field | input | 12 | Field to expand |
| dec_value | output | 32 | Expansion of dec_field |

## Verification
The bench feeds the encoder the expansion of every one of the 4096 fields. A search that stopped at the last fitting count instead of the first would show up on every value that wraps, such as 0x00000010. A search that put the rotation the wrong way round, or took count instead of twice count, would return fields whose round trip through the decoder misses the constant. Misses are tested with small non-fitting values and with a pseudo-random set. A block that range-checked the value or that leaked a stale byte on a miss would report a hit or a nonzero field. Latency is counted for each request against the smallest fitting count. Some requests are stalled with a second request offered, to catch a design that drops a held result or takes a new value while it is busy.

// File: rtl/imm_rot_pkg.sv
package imm_rot_pkg;

    localparam int WORD_W  = 32;
    localparam int IMM_W   = 8;
    localparam int ROT_W   = 4;
    localparam int FIELD_W = IMM_W + ROT_W;
    localparam int NUM_ROT = 2 ** ROT_W;
    localparam int AMT_W   = ROT_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DONE
    } scan_state_t;

    typedef struct packed {
        logic             hit;
        logic [ROT_W-1:0] rot;
        logic [IMM_W-1:0] imm;
    } enc_result_t;

    // rotate left by amt bits (amt below WORD_W)
    function automatic logic [WORD_W-1:0] rotl_word(input logic [WORD_W-1:0] v,
                                                    input logic [AMT_W-1:0]  amt);
        logic [2*WORD_W-1:0] d;
        d = {v, v} << amt;
        return d[2*WORD_W-1:WORD_W];
    endfunction

    // rotate right by amt bits (amt below WORD_W)
    function automatic logic [WORD_W-1:0] rotr_word(input logic [WORD_W-1:0] v,
                                                    input logic [AMT_W-1:0]  amt);
        logic [2*WORD_W-1:0] d;
        d = {v, v} >> amt;
        return d[WORD_W-1:0];
    endfunction

    // the field's rotate count counts pairs of bit positions
    function automatic logic [AMT_W-1:0] rot_amount(input logic [ROT_W-1:0] rot);
        return {rot, 1'b0};
    endfunction

    function automatic logic [FIELD_W-1:0] pack_field(input enc_result_t r);
        return {r.rot, r.imm};
    endfunction

endpackage

// File: rtl/imm_rot_probe.sv
// Tests one rotate count: the constant fits when rotating it back
// leaves nothing above the low byte.
module imm_rot_probe
    import imm_rot_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [ROT_W-1:0]  rot,
    output logic              fit,
    output logic [IMM_W-1:0]  imm
);

    logic [WORD_W-1:0] undone;

    always_comb begin
        undone = rotl_word(word, rot_amount(rot));
        fit    = ~|undone[WORD_W-1:IMM_W];
        imm    = undone[IMM_W-1:0];
    end

endmodule

// File: rtl/imm_rot_decode.sv
// Expands a 12-bit rotated-immediate field into its 32-bit value.
module imm_rot_decode
    import imm_rot_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    output logic [WORD_W-1:0]  value
);

    logic [WORD_W-1:0] byte_word;
    logic [ROT_W-1:0]  rot;

    always_comb begin
        byte_word = {{(WORD_W-IMM_W){1'b0}}, field[IMM_W-1:0]};
        rot       = field[FIELD_W-1:IMM_W];
        value     = rotr_word(byte_word, rot_amount(rot));
    end

endmodule

// File: rtl/imm_rot_scan_ctrl.sv
// Handshake and search sequencing: holds the constant, steps the base
// rotate count, and keeps the result until it is taken.
module imm_rot_scan_ctrl
    import imm_rot_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_value,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    input  enc_result_t       pick,
    output logic [WORD_W-1:0] scan_word,
    output logic [ROT_W-1:0]  scan_base,
    output enc_result_t       result
);

    localparam logic [ROT_W-1:0] LAST_BASE = ROT_W'(NUM_ROT - LANES);
    localparam logic [ROT_W-1:0] STEP      = ROT_W'(LANES);

    scan_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            scan_word <= '0;
            scan_base <= '0;
            result    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        scan_word <= in_value;
                        scan_base <= '0;
                        state     <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (pick.hit) begin
                        result <= pick;
                        state  <= ST_DONE;
                    end else if (scan_base == LAST_BASE) begin
                        result <= '0;
                        state  <= ST_DONE;
                    end else begin
                        scan_base <= scan_base + STEP;
                    end
                end
                ST_DONE: begin
                    if (out_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_DONE);

endmodule

// File: rtl/imm_rot_encoder.sv
// Top: search controller, LANES probes per cycle with lowest-count priority,
// and a free-standing field decoder.
module imm_rot_encoder
    import imm_rot_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_value,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_hit,
    output logic [FIELD_W-1:0] out_field,
    input  logic [FIELD_W-1:0] dec_field,
    output logic [WORD_W-1:0]  dec_value
);

    logic [WORD_W-1:0] scan_word;
    logic [ROT_W-1:0]  scan_base;
    enc_result_t       pick;
    enc_result_t       result;

    logic [LANES-1:0]  lane_fit;
    logic [ROT_W-1:0]  lane_rot [LANES];
    logic [IMM_W-1:0]  lane_imm [LANES];

    imm_rot_scan_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_value  (in_value),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .pick      (pick),
        .scan_word (scan_word),
        .scan_base (scan_base),
        .result    (result)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_rot[g] = scan_base + ROT_W'(g);
        imm_rot_probe u_probe (
            .word (scan_word),
            .rot  (lane_rot[g]),
            .fit  (lane_fit[g]),
            .imm  (lane_imm[g])
        );
    end

    // lowest lane wins so the smallest rotate count is reported
    always_comb begin
        pick = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (lane_fit[l]) begin
                pick.hit = 1'b1;
                pick.rot = lane_rot[l];
                pick.imm = lane_imm[l];
            end
        end
    end

    assign out_hit   = result.hit;
    assign out_field = pack_field(result);

    imm_rot_decode u_dec (
        .field (dec_field),
        .value (dec_value)
    );

endmodule

// File: rtl/imm_rot_encoder_chk.sv
module imm_rot_encoder_chk
    import imm_rot_pkg::*;
#(
    parameter int LANES = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic [WORD_W-1:0]  in_value,
    input logic               out_valid,
    input logic               out_ready,
    input logic               out_hit,
    input logic [FIELD_W-1:0] out_field,
    input logic [FIELD_W-1:0] dec_field,
    input logic [WORD_W-1:0]  dec_value
);

    logic [WORD_W-1:0] cap;
    logic [ROT_W+1:0]  lat;
    logic              busy;

    assign busy = !in_ready && !out_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
            lat <= '0;
        end else if (in_valid && in_ready) begin
            cap <= in_value;
            lat <= '0;
        end else if (busy) begin
            lat <= lat + 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    // R2
    roundtrip_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_hit) |->
        (rotl_word(cap, {out_field[FIELD_W-1:IMM_W], 1'b0}) ==
         {{(WORD_W-IMM_W){1'b0}}, out_field[IMM_W-1:0]}));

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_hit) |-> (out_field == '0));

    // R5
    latency_hit_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && out_hit) |->
        (int'(lat) == int'(out_field[FIELD_W-1:IMM_W]) / LANES + 1));

    // R5
    latency_miss_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && !out_hit) |-> (int'(lat) == NUM_ROT / LANES));

    // R6
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_hit) && $stable(out_field)));

    // R8
    dec_corner_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_field == 12'hFFF) |-> (dec_value == 32'h0000_03FC));

endmodule

bind imm_rot_encoder imm_rot_encoder_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_value  (in_value),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_hit   (out_hit),
    .out_field (out_field),
    .dec_field (dec_field),
    .dec_value (dec_value)
);

// File: tb/sim_imm_rot_encoder.sv
module sim_imm_rot_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_value = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_hit;
    logic [11:0] out_field;
    logic [11:0] dec_field = '0;
    logic [31:0] dec_value;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit finished = 0;

    imm_rot_encoder u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_value  (in_value),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_hit   (out_hit),
        .out_field (out_field),
        .dec_field (dec_field),
        .dec_value (dec_value)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > MAX_CYCLES && !finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, MAX_CYCLES);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_rotr(input logic [31:0] v, input int s);
        logic [63:0] d;
        d = {v, v} >> s;
        return d[31:0];
    endfunction

    function automatic logic [31:0] ref_decode(input logic [11:0] f);
        return ref_rotr({24'h0, f[7:0]}, 2 * int'(f[11:8]));
    endfunction

    // smallest c whose right-rotation of some byte gives v
    task automatic ref_encode(input logic [31:0] v, output bit hit,
                              output logic [11:0] field, output int lat);
        hit = 0;
        field = '0;
        lat = 16;
        for (int c = 0; c < 16; c++) begin
            for (int b = 0; b < 256 && !hit; b++) begin
                if (ref_rotr(32'(b), 2 * c) == v) begin
                    hit = 1;
                    field = {4'(c), 8'(b)};
                    lat = c + 1;
                end
            end
            if (hit) break;
        end
    endtask

    // fast path: byte candidate computed by rotating back
    task automatic ref_encode_fast(input logic [31:0] v, output bit hit,
                                   output logic [11:0] field, output int lat);
        logic [31:0] back;
        hit = 0;
        field = '0;
        lat = 16;
        for (int c = 0; c < 16; c++) begin
            back = ref_rotr(v, (32 - 2 * c) % 32);
            if (back < 32'd256 && ref_rotr(back, 2 * c) == v) begin
                hit = 1;
                field = {4'(c), back[7:0]};
                lat = c + 1;
                break;
            end
        end
    endtask

    task automatic run_enc(input logic [31:0] v, input bit stress, input bit slow_ref);
        bit          eh;
        logic [11:0] ef;
        int          el;
        int          cyc;
        logic        h_hit;
        logic [11:0] h_field;
        if (slow_ref) ref_encode(v, eh, ef, el);
        else          ref_encode_fast(v, eh, ef, el);
        in_valid = 1'b1;
        in_value = v;
        @(negedge clk);
        if (stress) begin
            in_value = ~v;
            chk(in_ready == 1'b0, "R6 busy in_ready", 32'(in_ready), 32'h0);
        end else begin
            in_valid = 1'b0;
        end
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!out_valid && cyc < 40);
        in_valid = 1'b0;
        chk(cyc == el, "R5 latency", 32'(cyc), 32'(el));
        chk(out_hit == eh, eh ? "R2 hit flag" : "R4 miss flag", 32'(out_hit), 32'(eh));
        chk(out_field == ef, eh ? "R3 field" : "R4 miss field", 32'(out_field), 32'(ef));
        if (out_hit) begin
            dec_field = out_field;
            #1;
            chk(dec_value == v, "R2 round trip", dec_value, v);
        end
        if (stress) begin
            h_hit = out_hit;
            h_field = out_field;
            in_valid = 1'b1;
            in_value = v ^ 32'h5A5A_0001;
            @(negedge clk);
            @(negedge clk);
            chk(out_valid && out_hit == h_hit && out_field == h_field,
                "R7 hold", {19'h0, out_valid, out_field}, {19'h1, h_field});
            chk(in_ready == 1'b0, "R6 no accept while held", 32'(in_ready), 32'h0);
            in_valid = 1'b0;
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && in_ready, "R7 retire to idle",
            {30'h0, out_valid, in_ready}, 32'h1);
    endtask

    initial begin
        logic [31:0] x;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 32'h1);
        chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'h0);
        @(negedge clk);
        chk(in_ready && !out_valid, "R1 idle holds", {30'h0, in_ready, out_valid}, 32'h2);

        // R9 named constants, exact fields
        run_enc(32'h0000_0023, 1'b0, 1'b1);
        chk(1'b1, "R9", 32'h0, 32'h0);
        in_valid = 1'b1; in_value = 32'h0000_0023; @(negedge clk); in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        chk(out_hit && out_field == 12'h023, "R9 0x23", 32'(out_field), 32'h023);
        out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
        in_valid = 1'b1; in_value = 32'h2300_0000; @(negedge clk); in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        chk(out_hit && out_field == 12'h423, "R9 0x23000000", 32'(out_field), 32'h423);
        out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
        in_valid = 1'b1; in_value = 32'h0; @(negedge clk); in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        chk(out_hit && out_field == 12'h000, "R9 zero", {19'h0, out_hit, out_field}, 32'h1000);
        out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;

        // R4 small non-fitting values; R3 wrap case
        run_enc(32'h0000_03FF, 1'b0, 1'b1);
        run_enc(32'h0000_0101, 1'b1, 1'b1);
        run_enc(32'h0000_0010, 1'b0, 1'b1);
        in_valid = 1'b1; in_value = 32'h0000_0010; @(negedge clk); in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        chk(out_field == 12'h010, "R3 lowest count", 32'(out_field), 32'h010);
        out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;

        // R2 R3 R5 sweep over the expansion of every field
        for (int f = 0; f < 4096; f++) begin
            run_enc(ref_decode(12'(f)), (f % 97) == 5, 1'b0);
        end

        // R4 pseudo-random constants, mostly misses
        x = 32'h1234_5679;
        for (int i = 0; i < 400; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            run_enc((i % 2 == 0) ? x : (x >> x[4:0]), (i % 50) == 7, 1'b0);
        end

        // R8 decoder sweep
        for (int f = 0; f < 4096; f++) begin
            dec_field = 12'(f);
            #1;
            chk(dec_value == ref_decode(12'(f)), "R8 decode", dec_value, ref_decode(12'(f)));
        end
        dec_field = 12'hFFF;
        #1;
        chk(dec_value == 32'h0000_03FC, "R8 0xFFF", dec_value, 32'h0000_03FC);

        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule